// File: doc/BRIEF.md
# Dual-Direction Byte Substitution Unit

This block substitutes one byte per transfer with either the forward or the inverse AES S-box. Both directions share a single GF(2^8) multiplicative-inverse core. The core is built from tower-field arithmetic and uses no stored table. The byte is mapped into GF(((2^2)^2)^2) with an isomorphism matrix, inverted there, and mapped back. A forward transfer runs the inverse core first and then the affine map with constant 0x63. An inverse transfer runs the inverse affine map with constant 0x05 first and then the inverse core. Multiplexers at both ends of the core choose the order. The zero byte has no inverse, so the core returns zero for it.

Bytes enter and leave on valid/ready streams. A byte moves on a clock edge where its valid and ready are both high. Each byte carries its own direction bit, so forward and inverse bytes can be mixed freely in one stream. By default one output register sits after the substitution logic. When that register is full and the consumer holds `out_ready` low, the block withholds `in_ready`, so a byte is never lost or overwritten. When the consumer keeps `out_ready` high, the block accepts and returns one byte per cycle.

Top module: `sbox_dual`

## Requirements
- R1: With `in_inv`=0 the output byte is the forward S-box value: the GF(2^8) inverse under x^8+x^4+x^3+x+1, then the affine map with constant 0x63 (for example 0x01 gives 0x7C and 0x53 gives 0xED).
- R2: The zero byte has no field inverse and is treated as its own inverse: forward 0x00 gives 0x63, and inverse 0x63 gives 0x00.
- R3: With `in_inv`=1 the output is the inverse S-box value: the inverse affine map with constant 0x05, then the field inverse. It undoes R1 for all 256 bytes.
- R4: The direction bit is taken together with each accepted byte, so consecutive transfers in alternating directions are each substituted in their own direction.
- R5: A byte accepted on a clock edge appears on `out_byte` with `out_valid` high right after that same edge.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_byte` stays unchanged and `in_ready` is low. The held byte is delivered exactly once.
- R7: After reset `out_valid` is low and `in_ready` is high.
- R8: With `out_ready` held high the block accepts a byte every cycle, and the output register empties when no new byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take the input byte on this edge |
| in_inv | input | 1 | Direction of this byte: 0 forward, 1 inverse |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Consumer takes the output byte on this edge |
| out_byte | output | 8 | Substituted byte |

## Verification
The hardest case to reach is a direction change that happens at the same moment as a stall. Here a byte of one direction is held in the output register while the next byte, in the other direction, waits at the input. A flaw in how the direction bit is latched would show up only in this situation. To reach it, the stimulus sends directions alternating byte by byte while the consumer drops `out_ready` on a pseudo-random pattern. A scoreboard compares every delivered byte against tables built independently by brute-force inverse search, covering all 256 bytes in each direction.

// File: rtl/sbox_dual_pkg.sv
package sbox_dual_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int PAIR_W = NIB_W / 2;

  localparam logic [BYTE_W-1:0] FWD_CONST = 8'h63;
  localparam logic [BYTE_W-1:0] INV_CONST = 8'h05;
  localparam logic [PAIR_W-1:0] PHI       = 2'b10;
  localparam logic [NIB_W-1:0]  LAMBDA    = 4'b1100;

  // GF(2^2) modulo x^2+x+1
  function automatic logic [1:0] gf4_mul(input logic [1:0] a, input logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  // inverse equals square in GF(2^2)
  function automatic logic [1:0] gf4_inv(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // GF((2^2)^2) modulo y^2+y+PHI
  function automatic logic [3:0] gf16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = gf4_mul(a[3:2], b[3:2]);
    return {hh ^ gf4_mul(a[3:2], b[1:0]) ^ gf4_mul(a[1:0], b[3:2]),
            gf4_mul(hh, PHI) ^ gf4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] gf16_inv(input logic [3:0] a);
    logic [1:0] d, di;
    d  = gf4_mul(gf4_mul(a[3:2], a[3:2]), PHI) ^ gf4_mul(a[3:2], a[1:0])
       ^ gf4_mul(a[1:0], a[1:0]);
    di = gf4_inv(d);
    return {gf4_mul(a[3:2], di), gf4_mul(a[3:2] ^ a[1:0], di)};
  endfunction

  // GF(((2^2)^2)^2) modulo z^2+z+LAMBDA
  function automatic logic [7:0] gf256t_mul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = gf16_mul(a[7:4], b[7:4]);
    return {hh ^ gf16_mul(a[7:4], b[3:0]) ^ gf16_mul(a[3:0], b[7:4]),
            gf16_mul(hh, LAMBDA) ^ gf16_mul(a[3:0], b[3:0])};
  endfunction

  // linear map given by eight packed columns
  function automatic logic [7:0] apply_cols(input logic [7:0] a, input logic [63:0] cols);
    logic [7:0] acc;
    acc = '0;
    for (int i = 0; i < 8; i++) if (a[i]) acc ^= cols[i*8 +: 8];
    return acc;
  endfunction

  // columns of the field-to-tower map: powers of a tower root of the field polynomial
  function automatic logic [63:0] tower_cols();
    logic [7:0] root, b, b2, b3, b4, b8, pw;
    logic       found;
    logic [63:0] cols;
    root  = 8'h02;
    found = 1'b0;
    for (int r = 2; r < 256; r++) begin
      b  = 8'(r);
      b2 = gf256t_mul(b, b);
      b3 = gf256t_mul(b2, b);
      b4 = gf256t_mul(b2, b2);
      b8 = gf256t_mul(b4, b4);
      if (!found && ((b8 ^ b4 ^ b3 ^ b ^ 8'h01) == 8'h00)) begin
        found = 1'b1;
        root  = b;
      end
    end
    pw = 8'h01;
    for (int i = 0; i < 8; i++) begin
      cols[i*8 +: 8] = pw;
      pw = gf256t_mul(pw, root);
    end
    return cols;
  endfunction

  // columns of the tower-to-field map, found by preimage search
  function automatic logic [63:0] field_cols(input logic [63:0] fwd);
    logic [63:0] cols;
    cols = '0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (apply_cols(8'(a), fwd) == (8'h01 << j)) cols[j*8 +: 8] = 8'(a);
    return cols;
  endfunction

endpackage

// File: rtl/sbox_affine_stage.sv
module sbox_affine_stage
  import sbox_dual_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  localparam logic [BYTE_W-1:0] K = INVERSE ? INV_CONST : FWD_CONST;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    if (INVERSE) begin : g_inv
      assign dout[i] = din[(i+2)%BYTE_W] ^ din[(i+5)%BYTE_W] ^ din[(i+7)%BYTE_W] ^ K[i];
    end else begin : g_fwd
      assign dout[i] = din[i] ^ din[(i+4)%BYTE_W] ^ din[(i+5)%BYTE_W]
                     ^ din[(i+6)%BYTE_W] ^ din[(i+7)%BYTE_W] ^ K[i];
    end
  end
endmodule

// File: rtl/sbox_tower_inv.sv
module sbox_tower_inv
  import sbox_dual_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout
);
  localparam logic [63:0] TO_TOWER = tower_cols();
  localparam logic [63:0] TO_FIELD = field_cols(TO_TOWER);

  logic [BYTE_W-1:0] t_in, t_inv;
  logic [NIB_W-1:0]  hi, lo, norm, norm_inv;

  always_comb begin
    t_in     = apply_cols(din, TO_TOWER);
    hi       = t_in[BYTE_W-1:NIB_W];
    lo       = t_in[NIB_W-1:0];
    norm     = gf16_mul(gf16_mul(hi, hi), LAMBDA) ^ gf16_mul(hi, lo) ^ gf16_mul(lo, lo);
    norm_inv = gf16_inv(norm);
    t_inv    = {gf16_mul(hi, norm_inv), gf16_mul(hi ^ lo, norm_inv)};
    dout     = apply_cols(t_inv, TO_FIELD);
  end
endmodule

// File: rtl/sbox_out_stage.sv
module sbox_out_stage
  import sbox_dual_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic              full_q;
    logic [BYTE_W-1:0] data_q;

    assign in_ready  = !full_q || out_ready;
    assign out_valid = full_q;
    assign out_data  = data_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= in_data;
      end
    end
  end else begin : g_wire
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end
endmodule

// File: rtl/sbox_dual.sv
module sbox_dual
  import sbox_dual_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_inv,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] pre_aff, core_in, core_out, post_aff, subst;

  sbox_affine_stage #(.INVERSE(1'b1)) u_pre (.din(in_byte), .dout(pre_aff));

  assign core_in = in_inv ? pre_aff : in_byte;

  sbox_tower_inv u_core (.din(core_in), .dout(core_out));

  sbox_affine_stage #(.INVERSE(1'b0)) u_post (.din(core_out), .dout(post_aff));

  assign subst = in_inv ? core_out : post_aff;

  sbox_out_stage #(.REG_OUT(REG_OUT)) u_out (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(subst),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_byte)
  );
endmodule

// File: rtl/sbox_dual_chk.sv
module sbox_dual_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_inv,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte
);
  if (REG_OUT) begin : g_chk
    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
    // R6
    a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
    // R5
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);
    // R8
    a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_ready) |=> !out_valid);
    // R2
    a_r2_zero_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_inv && in_byte == 8'h00) |=> (out_byte == 8'h63));
    // R2
    a_r2_zero_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_inv && in_byte == 8'h63) |=> (out_byte == 8'h00));
  end
endmodule

bind sbox_dual sbox_dual_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_inv(in_inv), .in_byte(in_byte), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte)
);

// File: tb/sbox_dual_bench.sv
`timescale 1ns/1ps
module sbox_dual_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_inv = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  logic [7:0] fwd_tab [256];
  logic [7:0] inv_tab [256];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sbox_dual u_sbox_dual (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inv(in_inv), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0; x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit inv, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_byte = b; in_inv = inv;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(inv ? inv_tab[b] : fwd_tab[b]);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // back-pressure source
  always @(negedge clk) out_ready <= bp_mode ? ($urandom % 3 != 0) : 1'b1;

  // monitor: compares deliveries and checks stall holding
  bit         stall_q = 1'b0;
  logic [7:0] stall_b = '0;
  always @(negedge clk) begin
    #1.5;
    if (rst_n) begin
      if (stall_q)
        check(out_valid && out_byte == stall_b, "R6 hold", out_byte, stall_b);
      if (out_valid && !out_ready) begin
        check(!in_ready, "R6 in_ready low", {7'd0, in_ready}, 8'h00);
        stall_q = 1'b1; stall_b = out_byte;
      end else stall_q = 1'b0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R6 extra output", out_byte, 8'h00);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_byte == e, t, out_byte, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int t0;
    for (int a = 0; a < 256; a++) begin
      logic [7:0] x;
      x = 8'h00;
      for (int b = 1; b < 256; b++) if (ref_mul(8'(a), 8'(b)) == 8'h01) x = 8'(b);
      fwd_tab[a] = x ^ rotl(x, 1) ^ rotl(x, 2) ^ rotl(x, 3) ^ rotl(x, 4) ^ 8'h63;
    end
    for (int a = 0; a < 256; a++) inv_tab[fwd_tab[a]] = 8'(a);

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R7
    check(!out_valid && in_ready, "R7 reset state", {6'd0, out_valid, in_ready}, 8'h01);

    // R2 explicit zero cases and R5 latency
    send(8'h00, 1'b0, "R2 fwd zero");
    idle(); #1;
    check(out_valid, "R5 latency", {7'd0, out_valid}, 8'h01);
    send(8'h63, 1'b1, "R2 inv zero");
    idle(); drain();
    send(8'h01, 1'b0, "R1 fwd 01");
    send(8'h53, 1'b0, "R1 fwd 53");
    idle(); drain();
    check(fwd_tab[8'h53] == 8'hED, "R1 table sanity", fwd_tab[8'h53], 8'hED);

    // R1 and R8: all bytes forward, back to back
    t0 = cyc;
    for (int a = 0; a < 256; a++) send(8'(a), 1'b0, "R1 forward sweep");
    idle(); drain();
    check((cyc - t0) <= 260, "R8 one per cycle", 8'(cyc - t0), 8'(260));
    #1;
    check(!out_valid, "R8 drained", {7'd0, out_valid}, 8'h00);

    // R3: all bytes inverse
    for (int a = 0; a < 256; a++) send(8'(a), 1'b1, "R3 inverse sweep");
    idle(); drain();

    // R4 and R6: alternating directions under back-pressure
    bp_mode = 1'b1;
    for (int a = 0; a < 512; a++) send(8'((a * 37) & 255), a[0], "R4 alternating stall");
    idle(); drain();
    bp_mode = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule